// File: doc/BRIEF.md
# Write-Combining Media Line Buffer

This block sits between a host port that moves one 64-byte sector per request and a storage media port that can only read or write whole aligned 256-byte lines of four sectors. It keeps up to 64 lines in local entries. Host writes to the same line gather in one entry, so several sector writes become a single media line write. A host read that misses pulls the whole line from the media, and later reads of any sector in that line are answered locally. The same entries therefore serve both as a write combiner and as a read cache.

A write counts as durable once it is stored in an entry, so write-back happens whenever the buffer needs room or a flush is asked for, in any order across lines. A line whose four sectors were all written by the host goes to the media without a read. A line with only some sectors written is first read from the media, the unwritten sectors are filled in, and the completed line is written back. When all entries are in use, a new line takes the least recently used entry. A dirty victim is written back before the entry is reused.

Host requests and responses are valid/ready streams with one request in flight. The host may hold `rsp_ready` low for as long as it likes. The response then stays valid with stable data, and no new request is taken. The media side issues one line operation at a time and holds it until the media acknowledges it.

Top module: `wcb_line_buffer`

## Requirements
- R1: A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the response has been consumed, and also while a flush runs.
- R2: A write to a line that is already buffered, or to a line that gets a clean or free entry, is answered with one response and causes no media operation.
- R3: Four writes that together cover all four sectors of one line, followed by a flush, cause exactly one media line write and no media read.
- R4: Writing back a line with only some sectors written performs one media read of that line and then one media write. Sectors written by the host keep the host data, and every other sector keeps the media content.
- R5: A read miss causes one media read of the line and returns the requested sector from it. Reads of the other sectors of that line then cause no media operation.
- R6: In a line holding host-written sectors, a read of a written sector returns the host data without media access. A read of an unwritten sector fetches the line and returns media data, and the written sectors keep the host data afterwards.
- R7: With every entry in use, a new line replaces the least recently used entry, and any access counts as a use. A dirty victim is written back before its entry is reused.
- R8: A one-cycle `flush_req` while idle writes back every dirty entry and then raises `flush_done` for exactly one cycle. A flush that finds nothing dirty performs no media operation.
- R9: A media request stays high, with its address, direction and write data unchanged, until the cycle it is acknowledged. No media request is raised while the block is idle.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_rdata` stays unchanged.
- R11: After reset, no entry holds a line, `req_ready` is high, and `rsp_valid`, `flush_done` and `med_req_valid` are low.
- R12: Host address bits [1:0] select the sector within a line, and the upper bits form the media line address. Sector k travels on media data bits [512k+511:512k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = sector write, 0 = sector read |
| req_addr | input | 22 | Sector address: {line, sector} |
| req_wdata | input | 512 | Write data for one sector |
| rsp_valid | output | 1 | Response valid (read data or write acknowledge) |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 512 | Read data; zero for a write acknowledge |
| flush_req | input | 1 | Start writing back all dirty entries |
| flush_done | output | 1 | One-cycle pulse when the flush has finished |
| med_req_valid | output | 1 | Media line operation requested |
| med_req_write | output | 1 | 1 = line write, 0 = line read |
| med_addr | output | 20 | Media line address |
| med_wdata | output | 2048 | Line data for a media write |
| med_ack | input | 1 | Media completes the current operation |
| med_rdata | input | 2048 | Line data from a media read, valid with `med_ack` |

## Verification
Two functions meet in the same cycle. When a line fetch returns for an entry that already holds host-written sectors, the media data and the host data are merged in a single store update. This is provoked by writing one sector, reading a different sector of the same line, and then reading the written sector again. It is judged by comparing both reads against a reference model of host-visible memory. The second meeting point is eviction, where one host request both writes back a dirty, partly written victim and allocates its entry. This is provoked by filling all entries, refreshing the oldest one, and writing a new line. It is judged by counting the media reads and writes, checking the address of the line written back, and reading the evicted sector back from the media.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_WB_RD,
    ST_WB_WR,
    ST_FILL,
    ST_FL_SCAN,
    ST_RESP
  } wcb_state_e;
endpackage

// File: rtl/wcb_tag_store.sv
module wcb_tag_store #(
  parameter int ENTRIES    = 64,
  parameter int LINE_SECTS = 4,
  parameter int LINE_AW    = 20,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int SEL_W     = $clog2(LINE_SECTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINE_AW-1:0]    look_tag,
  output logic                  hit,
  output logic [IDX_W-1:0]      hit_idx,
  output logic [IDX_W-1:0]      vict_idx,
  output logic                  vict_valid,
  output logic                  vict_dirty,
  output logic                  any_dirty,
  output logic [IDX_W-1:0]      dirty_idx,
  input  logic [IDX_W-1:0]      op_idx,
  output logic [LINE_AW-1:0]    op_tag,
  output logic [LINE_SECTS-1:0] op_wmask,
  output logic [LINE_SECTS-1:0] op_pmask,
  input  logic                  alloc_en,
  input  logic                  touch_en,
  input  logic                  sect_wr_en,
  input  logic [SEL_W-1:0]      sect_sel,
  input  logic                  merge_en,
  input  logic                  clean_en
);
  logic [LINE_AW-1:0]    tag   [ENTRIES];
  logic                  valid [ENTRIES];
  logic                  dirty [ENTRIES];
  logic [LINE_SECTS-1:0] wmask [ENTRIES];
  logic [LINE_SECTS-1:0] pmask [ENTRIES];
  logic [IDX_W-1:0]      age   [ENTRIES];

  // lookup, victim choice and dirty scan
  always_comb begin
    logic found;
    hit = 1'b0;
    hit_idx = '0;
    any_dirty = 1'b0;
    dirty_idx = '0;
    found = 1'b0;
    vict_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid[i] && tag[i] == look_tag && !hit) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (valid[i] && dirty[i] && !any_dirty) begin
        any_dirty = 1'b1;
        dirty_idx = IDX_W'(i);
      end
      if (!valid[i] && !found) begin
        found = 1'b1;
        vict_idx = IDX_W'(i);
      end
    end
    if (!found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (age[i] == IDX_W'(ENTRIES - 1)) vict_idx = IDX_W'(i);
      end
    end
    vict_valid = valid[vict_idx];
    vict_dirty = dirty[vict_idx];
  end

  assign op_tag   = tag[op_idx];
  assign op_wmask = wmask[op_idx];
  assign op_pmask = pmask[op_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        valid[i] <= 1'b0;
        dirty[i] <= 1'b0;
        wmask[i] <= '0;
        pmask[i] <= '0;
        tag[i]   <= '0;
        age[i]   <= IDX_W'(i);
      end
    end else begin
      if (alloc_en) begin
        valid[op_idx] <= 1'b1;
        dirty[op_idx] <= 1'b0;
        tag[op_idx]   <= look_tag;
        wmask[op_idx] <= '0;
        pmask[op_idx] <= '0;
      end
      if (sect_wr_en) begin
        wmask[op_idx][sect_sel] <= 1'b1;
        pmask[op_idx][sect_sel] <= 1'b1;
        dirty[op_idx] <= 1'b1;
      end
      if (merge_en) pmask[op_idx] <= '1;
      if (clean_en) begin
        dirty[op_idx] <= 1'b0;
        wmask[op_idx] <= '0;
      end
      if (touch_en) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == op_idx) age[i] <= '0;
          else if (age[i] < age[op_idx]) age[i] <= age[i] + 1'b1;
        end
      end
    end
  end

  // R7: an entry is never re-tagged while it still holds unwritten-back data
  a_r7_clean_before_reuse: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !(valid[op_idx] && dirty[op_idx]));
  // R4: a line only becomes clean once every sector holds valid data
  a_r4_line_complete_on_clean: assert property (@(posedge clk) disable iff (!rst_n)
    clean_en |-> &(wmask[op_idx] | pmask[op_idx]));
endmodule

// File: rtl/wcb_data_store.sv
module wcb_data_store #(
  parameter int ENTRIES    = 64,
  parameter int LINE_SECTS = 4,
  parameter int SECT_W     = 512,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int SEL_W     = $clog2(LINE_SECTS),
  localparam int LINE_W    = SECT_W * LINE_SECTS
) (
  input  logic                  clk,
  input  logic [IDX_W-1:0]      idx,
  input  logic [SEL_W-1:0]      sect_sel,
  input  logic                  sect_wr_en,
  input  logic [SECT_W-1:0]     sect_wdata,
  input  logic                  merge_en,
  input  logic [LINE_SECTS-1:0] merge_keep,
  input  logic [LINE_W-1:0]     line_wdata,
  output logic [LINE_W-1:0]     line_rdata,
  output logic [SECT_W-1:0]     sect_rdata
);
  for (genvar s = 0; s < LINE_SECTS; s++) begin : g_bank
    logic [SECT_W-1:0] bank [ENTRIES];
    always_ff @(posedge clk) begin
      if (sect_wr_en && sect_sel == SEL_W'(s))
        bank[idx] <= sect_wdata;
      else if (merge_en && !merge_keep[s])
        bank[idx] <= line_wdata[s*SECT_W +: SECT_W];
    end
    assign line_rdata[s*SECT_W +: SECT_W] = bank[idx];
  end

  assign sect_rdata = line_rdata[sect_sel*SECT_W +: SECT_W];

  // R6: a host sector write and a media merge never target the store together
  a_r6_no_dual_update: assert property (@(posedge clk) !(sect_wr_en && merge_en));
endmodule

// File: rtl/wcb_ctrl.sv
module wcb_ctrl
  import wcb_pkg::*;
#(
  parameter int ENTRIES    = 64,
  parameter int LINE_SECTS = 4,
  parameter int SECT_W     = 512,
  parameter int LINE_AW    = 20,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int SEL_W     = $clog2(LINE_SECTS),
  localparam int HOST_AW   = LINE_AW + SEL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [HOST_AW-1:0]    req_addr,
  input  logic [SECT_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [SECT_W-1:0]     rsp_rdata,
  input  logic                  flush_req,
  output logic                  flush_done,
  output logic                  med_req_valid,
  output logic                  med_req_write,
  input  logic                  med_ack,
  output logic [LINE_AW-1:0]    look_tag,
  input  logic                  hit,
  input  logic [IDX_W-1:0]      hit_idx,
  input  logic [IDX_W-1:0]      vict_idx,
  input  logic                  vict_valid,
  input  logic                  vict_dirty,
  input  logic                  any_dirty,
  input  logic [IDX_W-1:0]      dirty_idx,
  output logic [IDX_W-1:0]      op_idx,
  input  logic [LINE_SECTS-1:0] op_wmask,
  input  logic [LINE_SECTS-1:0] op_pmask,
  output logic                  alloc_en,
  output logic                  touch_en,
  output logic                  sect_wr_en,
  output logic [SEL_W-1:0]      sect_sel,
  output logic                  merge_en,
  output logic                  clean_en,
  output logic [SECT_W-1:0]     sect_wdata,
  input  logic [SECT_W-1:0]     sect_rdata
);
  wcb_state_e state_q, state_d;
  logic [IDX_W-1:0]   cur_q, cur_d;
  logic               ret_flush_q, ret_flush_d;
  logic               q_write;
  logic [HOST_AW-1:0] q_addr;
  logic [SECT_W-1:0]  q_wdata;
  logic [SECT_W-1:0]  rdata_q, rdata_d;
  logic [LINE_SECTS-1:0] have;

  assign look_tag   = q_addr[HOST_AW-1:SEL_W];
  assign sect_sel   = q_addr[SEL_W-1:0];
  assign sect_wdata = q_wdata;
  assign have       = op_wmask | op_pmask;

  assign req_ready     = (state_q == ST_IDLE) && !flush_req;
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_rdata     = rdata_q;
  assign med_req_valid = (state_q == ST_WB_RD) || (state_q == ST_WB_WR) || (state_q == ST_FILL);
  assign med_req_write = (state_q == ST_WB_WR);
  assign flush_done    = (state_q == ST_FL_SCAN) && !any_dirty;

  always_comb begin
    unique case (state_q)
      ST_DECIDE:  op_idx = hit ? hit_idx : vict_idx;
      ST_FL_SCAN: op_idx = dirty_idx;
      default:    op_idx = cur_q;
    endcase
  end

  always_comb begin
    state_d     = state_q;
    cur_d       = cur_q;
    ret_flush_d = ret_flush_q;
    rdata_d     = rdata_q;
    alloc_en    = 1'b0;
    touch_en    = 1'b0;
    sect_wr_en  = 1'b0;
    merge_en    = 1'b0;
    clean_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (flush_req) state_d = ST_FL_SCAN;
        else if (req_valid) state_d = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (hit) begin
          if (q_write) begin
            sect_wr_en = 1'b1;
            touch_en   = 1'b1;
            rdata_d    = '0;
            state_d    = ST_RESP;
          end else if (have[sect_sel]) begin
            touch_en = 1'b1;
            rdata_d  = sect_rdata;
            state_d  = ST_RESP;
          end else begin
            cur_d   = hit_idx;
            state_d = ST_FILL;
          end
        end else if (vict_valid && vict_dirty) begin
          cur_d       = vict_idx;
          ret_flush_d = 1'b0;
          state_d     = (&op_wmask) ? ST_WB_WR : ST_WB_RD;
        end else begin
          alloc_en = 1'b1;
        end
      end
      ST_WB_RD: begin
        if (med_ack) begin
          merge_en = 1'b1;
          state_d  = ST_WB_WR;
        end
      end
      ST_WB_WR: begin
        if (med_ack) begin
          clean_en = 1'b1;
          state_d  = ret_flush_q ? ST_FL_SCAN : ST_DECIDE;
        end
      end
      ST_FILL: begin
        if (med_ack) begin
          merge_en = 1'b1;
          state_d  = ST_DECIDE;
        end
      end
      ST_FL_SCAN: begin
        if (any_dirty) begin
          cur_d       = dirty_idx;
          ret_flush_d = 1'b1;
          state_d     = (&op_wmask) ? ST_WB_WR : ST_WB_RD;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      ret_flush_q <= 1'b0;
      rdata_q     <= '0;
      q_write     <= 1'b0;
      q_addr      <= '0;
      q_wdata     <= '0;
    end else begin
      state_q     <= state_d;
      cur_q       <= cur_d;
      ret_flush_q <= ret_flush_d;
      rdata_q     <= rdata_d;
      if (req_valid && req_ready) begin
        q_write <= req_write;
        q_addr  <= req_addr;
        q_wdata <= req_wdata;
      end
    end
  end

  // R1: no new request is taken while a response is waiting
  a_r1_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R10: a stalled response keeps its data
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R9: an unacknowledged media request is held unchanged
  a_r9_med_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (med_req_valid && !med_ack) |=> (med_req_valid && $stable(med_req_write) && $stable(op_idx)));
  // R8: flush completion is a single-cycle pulse
  a_r8_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);
endmodule

// File: rtl/wcb_line_buffer.sv
module wcb_line_buffer #(
  parameter int SECT_BYTES = 64,
  parameter int LINE_SECTS = 4,
  parameter int ENTRIES    = 64,
  parameter int LINE_AW    = 20,
  localparam int SECT_W    = SECT_BYTES * 8,
  localparam int LINE_W    = SECT_W * LINE_SECTS,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int SEL_W     = $clog2(LINE_SECTS),
  localparam int HOST_AW   = LINE_AW + SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [HOST_AW-1:0] req_addr,
  input  logic [SECT_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [SECT_W-1:0]  rsp_rdata,
  input  logic               flush_req,
  output logic               flush_done,
  output logic               med_req_valid,
  output logic               med_req_write,
  output logic [LINE_AW-1:0] med_addr,
  output logic [LINE_W-1:0]  med_wdata,
  input  logic               med_ack,
  input  logic [LINE_W-1:0]  med_rdata
);
  logic [LINE_AW-1:0]    look_tag;
  logic                  hit, vict_valid, vict_dirty, any_dirty;
  logic [IDX_W-1:0]      hit_idx, vict_idx, dirty_idx, op_idx;
  logic [LINE_SECTS-1:0] op_wmask, op_pmask;
  logic                  alloc_en, touch_en, sect_wr_en, merge_en, clean_en;
  logic [SEL_W-1:0]      sect_sel;
  logic [SECT_W-1:0]     sect_wdata, sect_rdata;

  wcb_ctrl #(.ENTRIES(ENTRIES), .LINE_SECTS(LINE_SECTS), .SECT_W(SECT_W), .LINE_AW(LINE_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .flush_req(flush_req), .flush_done(flush_done),
    .med_req_valid(med_req_valid), .med_req_write(med_req_write), .med_ack(med_ack),
    .look_tag(look_tag), .hit(hit), .hit_idx(hit_idx), .vict_idx(vict_idx),
    .vict_valid(vict_valid), .vict_dirty(vict_dirty), .any_dirty(any_dirty),
    .dirty_idx(dirty_idx), .op_idx(op_idx), .op_wmask(op_wmask), .op_pmask(op_pmask),
    .alloc_en(alloc_en), .touch_en(touch_en), .sect_wr_en(sect_wr_en),
    .sect_sel(sect_sel), .merge_en(merge_en), .clean_en(clean_en),
    .sect_wdata(sect_wdata), .sect_rdata(sect_rdata)
  );

  wcb_tag_store #(.ENTRIES(ENTRIES), .LINE_SECTS(LINE_SECTS), .LINE_AW(LINE_AW)) u_tags (
    .clk(clk), .rst_n(rst_n), .look_tag(look_tag),
    .hit(hit), .hit_idx(hit_idx), .vict_idx(vict_idx),
    .vict_valid(vict_valid), .vict_dirty(vict_dirty),
    .any_dirty(any_dirty), .dirty_idx(dirty_idx),
    .op_idx(op_idx), .op_tag(med_addr), .op_wmask(op_wmask), .op_pmask(op_pmask),
    .alloc_en(alloc_en), .touch_en(touch_en), .sect_wr_en(sect_wr_en),
    .sect_sel(sect_sel), .merge_en(merge_en), .clean_en(clean_en)
  );

  wcb_data_store #(.ENTRIES(ENTRIES), .LINE_SECTS(LINE_SECTS), .SECT_W(SECT_W)) u_data (
    .clk(clk), .idx(op_idx), .sect_sel(sect_sel),
    .sect_wr_en(sect_wr_en), .sect_wdata(sect_wdata),
    .merge_en(merge_en), .merge_keep(op_wmask), .line_wdata(med_rdata),
    .line_rdata(med_wdata), .sect_rdata(sect_rdata)
  );
endmodule

// File: tb/wcb_line_buffer_test.sv
`timescale 1ns/1ps
module wcb_line_buffer_test;
  localparam int HAW = 22;
  localparam int LAW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0, flush_req = 1'b0;
  logic [HAW-1:0] req_addr = '0;
  logic [511:0] req_wdata = '0;
  logic req_ready, rsp_valid, flush_done, med_req_valid, med_req_write;
  logic [511:0] rsp_rdata;
  logic [LAW-1:0] med_addr;
  logic [2047:0] med_wdata;
  logic med_ack = 1'b0;
  logic [2047:0] med_rdata = '0;

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, last_wr_addr = -1;
  bit last_op = 1'b0, prev_op = 1'b0;
  logic [2047:0] mmem [int];
  logic [511:0] sref [int];

  always #4 clk = ~clk;

  wcb_line_buffer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .flush_req(flush_req), .flush_done(flush_done),
    .med_req_valid(med_req_valid), .med_req_write(med_req_write),
    .med_addr(med_addr), .med_wdata(med_wdata), .med_ack(med_ack), .med_rdata(med_rdata)
  );

  function automatic logic [2047:0] init_line(int l);
    logic [2047:0] r;
    for (int w = 0; w < 64; w++) r[w*32 +: 32] = {16'(l) ^ 16'hC3A5, 8'(w), 8'h3C};
    return r;
  endfunction

  function automatic logic [2047:0] media_line(int l);
    if (mmem.exists(l)) return mmem[l];
    return init_line(l);
  endfunction

  function automatic logic [511:0] exp_sect(int a);
    logic [2047:0] ln;
    if (sref.exists(a)) return sref[a];
    ln = init_line(a >> 2);
    return ln[(a & 3)*512 +: 512];
  endfunction

  function automatic logic [511:0] dpat(int s);
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[k*32 +: 32] = (32'(s) * 32'h9E3779B1) ^ 32'(k*7 + 1);
    return r;
  endfunction

  // media model: one-cycle acknowledge, line-addressed storage
  initial begin
    forever begin
      @(negedge clk);
      if (med_ack) med_ack = 1'b0;
      else if (med_req_valid) begin
        if (med_req_write) begin
          mmem[int'(med_addr)] = med_wdata;
          n_wr++;
          last_wr_addr = int'(med_addr);
        end else begin
          med_rdata = media_line(int'(med_addr));
          n_rd++;
        end
        prev_op = last_op;
        last_op = med_req_write;
        med_ack = 1'b1;
      end
    end
  end

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_op(input bit wr, input int addr, input logic [511:0] wd,
                         output logic [511:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = HAW'(addr); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    if (wr) sref[addr] = wd;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    while (!flush_done) @(negedge clk);
    @(negedge clk);
    chk("R8 flush_done single cycle", 512'(flush_done), 512'(0));
  endtask

  task automatic t_reset();
    chk("R11 req_ready after reset", 512'(req_ready), 512'(1));
    chk("R11 rsp_valid after reset", 512'(rsp_valid), 512'(0));
    chk("R11 flush_done after reset", 512'(flush_done), 512'(0));
    chk("R9 R11 no media request when idle", 512'(med_req_valid), 512'(0));
  endtask

  task automatic t_fill_read();
    logic [511:0] d;
    int r0;
    r0 = n_rd;
    host_op(0, 5*4 + 2, '0, d);
    chk("R5 miss data", d, exp_sect(5*4 + 2));
    chk("R5 one media read on miss", 512'(n_rd - r0), 512'(1));
    for (int s = 0; s < 4; s++) begin
      host_op(0, 5*4 + s, '0, d);
      chk("R5 R12 hit data", d, exp_sect(5*4 + s));
    end
    chk("R5 no media read on hits", 512'(n_rd - r0), 512'(1));
  endtask

  task automatic t_combine();
    logic [511:0] d;
    logic [2047:0] exp_line;
    int r0, w0;
    r0 = n_rd; w0 = n_wr;
    for (int s = 0; s < 4; s++) host_op(1, 6*4 + s, dpat(60 + s), d);
    chk("R2 no media op on buffered writes", 512'((n_rd - r0) + (n_wr - w0)), 512'(0));
    do_flush();
    chk("R3 one media write", 512'(n_wr - w0), 512'(1));
    chk("R3 no media read", 512'(n_rd - r0), 512'(0));
    for (int s = 0; s < 4; s++) exp_line[s*512 +: 512] = dpat(60 + s);
    chk("R12 sector 0 position", media_line(6)[511:0], exp_line[511:0]);
    chk("R12 sector 3 position", media_line(6)[2047:1536], exp_line[2047:1536]);
  endtask

  task automatic t_partial();
    logic [511:0] d;
    logic [2047:0] ln;
    int r0, w0;
    host_op(1, 7*4 + 1, dpat(71), d);
    r0 = n_rd; w0 = n_wr;
    do_flush();
    chk("R4 one media read", 512'(n_rd - r0), 512'(1));
    chk("R4 one media write", 512'(n_wr - w0), 512'(1));
    chk("R4 read before write", 512'({prev_op, last_op}), 512'(2'b01));
    ln = media_line(7);
    chk("R4 written sector kept", ln[1*512 +: 512], dpat(71));
    chk("R4 other sector from media", ln[2*512 +: 512], init_line(7)[2*512 +: 512]);
  endtask

  task automatic t_partial_read();
    logic [511:0] d;
    int r0;
    host_op(1, 8*4 + 3, dpat(83), d);
    r0 = n_rd;
    host_op(0, 8*4 + 3, '0, d);
    chk("R6 written sector read", d, dpat(83));
    chk("R6 no media on written read", 512'(n_rd - r0), 512'(0));
    host_op(0, 8*4 + 0, '0, d);
    chk("R6 unwritten sector from media", d, exp_sect(8*4));
    chk("R6 fill on unwritten read", 512'(n_rd - r0), 512'(1));
    host_op(0, 8*4 + 3, '0, d);
    chk("R6 written data survives fill", d, dpat(83));
  endtask

  task automatic t_backpressure();
    logic [511:0] d0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = HAW'(6*4 + 1);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 not ready after accept", 512'(req_ready), 512'(0));
    while (!rsp_valid) @(negedge clk);
    d0 = rsp_rdata;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 rsp held", 512'(rsp_valid), 512'(1));
      chk("R10 data stable", rsp_rdata, d0);
      chk("R1 no accept while rsp pending", 512'(req_ready), 512'(0));
    end
    chk("R10 data value", d0, exp_sect(6*4 + 1));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10 rsp taken", 512'(rsp_valid), 512'(0));
  endtask

  task automatic t_lru();
    logic [511:0] d;
    int r0, w0;
    do_flush();
    for (int i = 0; i < 64; i++) host_op(1, (200 + i)*4, dpat(200 + i), d);
    r0 = n_rd; w0 = n_wr;
    host_op(0, 200*4, '0, d);
    chk("R7 oldest line still buffered", d, dpat(200));
    chk("R7 hit without media", 512'((n_rd - r0) + (n_wr - w0)), 512'(0));
    host_op(1, 300*4, dpat(300), d);
    chk("R7 victim write-back read", 512'(n_rd - r0), 512'(1));
    chk("R7 victim write-back write", 512'(n_wr - w0), 512'(1));
    chk("R7 victim is least recent", 512'(last_wr_addr), 512'(201));
    chk("R7 victim data on media", media_line(201)[511:0], dpat(201));
    r0 = n_rd; w0 = n_wr;
    host_op(0, 200*4, '0, d);
    chk("R7 touched line kept", 512'((n_rd - r0) + (n_wr - w0)), 512'(0));
    host_op(0, 201*4, '0, d);
    chk("R7 evicted line read back", d, dpat(201));
    chk("R7 second eviction writes line", 512'(last_wr_addr), 512'(202));
    chk("R7 reads for wb and fill", 512'(n_rd - r0), 512'(2));
  endtask

  task automatic t_flush_twice();
    int r0, w0;
    do_flush();
    r0 = n_rd; w0 = n_wr;
    do_flush();
    chk("R8 clean flush no media", 512'((n_rd - r0) + (n_wr - w0)), 512'(0));
    chk("R8 after flush ready", 512'(req_ready), 512'(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_read();
    t_combine();
    t_partial();
    t_partial_read();
    t_backpressure();
    t_lru();
    t_flush_twice();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule